// File: doc/BRIEF.md
# Counting Timeout Interrupt Controller

This block gathers the interrupt events of a regulator controller with four switched outputs. Each output reports, per charge event, either a pulse meaning "this charge hit the switch timeout" or a pulse meaning "this charge ended cleanly". A small counter per output tallies timeouts. When the tally reaches a programmable trigger value, a sticky status bit is set. A programmable number of clean charges in a row wipes the tally, so isolated timeouts that are followed by healthy operation never raise an interrupt.

A fifth source comes from a battery low-voltage comparator. That level is asynchronous, so it is passed through a synchronizer, and each new assertion raises one status event. Software clears status bits by writing ones to a clear strobe. It blocks sources through a mask register. One combined interrupt line drives the system interrupt controller.

Status bit positions: bits 0 to 3 belong to outputs 0 to 3, and bit 4 belongs to the battery low-voltage source. The mask uses the same positions.

Top module: `tmo_irq_ctrl`

## Requirements
- R1: After reset, `status_o`, `mask_o` and `irq_o` are all zero.
- R2: A timeout pulse on output i adds one to that output's tally. Status bit i sets at the clock edge that samples the pulse bringing the tally to `trig_cfg_i`. Pulses before that leave the bit clear.
- R3: A `trig_cfg_i` of 0 acts as 1, so the first timeout sets the status bit.
- R4: `reset_cfg_i` clean charge pulses in a row, with no timeout between them, clear output i's tally. A timeout inside the run restarts the run count without clearing the tally.
- R5: A `reset_cfg_i` of 0 clears the tally on every clean charge pulse.
- R6: A status bit stays set until a cycle with `clr_we_i` high and a 1 in that bit of `clr_data_i`. Zero bits in `clr_data_i` leave their status bits unchanged.
- R7: If a set event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: `mask_we_i` loads `mask_data_i` into `mask_o`. A mask bit of 1 keeps its source out of `irq_o`, but the status bit still records the event. `irq_o` is high when any status bit whose mask bit is 0 is set.
- R9: `vbat_low_i` (1 = battery below 2.5 V) passes through a two-flop synchronizer. Status bit 4 sets on the third clock edge after the input rises. Holding the level high raises no further event after a clear. A new rise raises a new event.
- R10: The tally saturates at its maximum (15) instead of wrapping. While the tally is at or above the trigger, each further timeout sets the status bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_evt_i | input | N_OUT | Per-output pulse: a charge ended by timeout |
| clean_evt_i | input | N_OUT | Per-output pulse: a charge finished without timeout |
| vbat_low_i | input | 1 | Asynchronous battery-below-threshold level |
| trig_cfg_i | input | CNT_W | Timeout count that raises the interrupt |
| reset_cfg_i | input | CNT_W | Clean-charge run length that clears the tally |
| clr_we_i | input | 1 | Clear strobe |
| clr_data_i | input | N_OUT+1 | Write-one-to-clear bit pattern |
| mask_we_i | input | 1 | Mask write strobe |
| mask_data_i | input | N_OUT+1 | New mask value |
| status_o | output | N_OUT+1 | Sticky interrupt status |
| mask_o | output | N_OUT+1 | Current mask |
| irq_o | output | 1 | Combined unmasked interrupt |

## Verification
The bench targets the off-by-one edges of the two counts. If the trigger compare is off by one, the status sets one timeout early or late. A run counter that is not restarted by a timeout would clear the tally too soon and hide the interrupt. The zero settings are exercised too: a trigger of 0 read literally would never fire. The bench pits a clear against a new event in the same cycle, where a wrong priority drops a real event. It holds the battery level high across a clear, where a level-sensitive design would raise the bit again at once. Finally it drives sixteen timeouts at a trigger of 15, where a tally that wraps would miss the re-raise.

// File: rtl/tmo_irq_pkg.sv
package tmo_irq_pkg;
   localparam int unsigned DEF_OUTS        = 4;
   localparam int unsigned DEF_CNT_W       = 4;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // Edge that marks a new battery-low event on the synchronized level
   typedef enum logic { EDGE_FALL = 1'b0, EDGE_RISE = 1'b1 } edge_sel_e;
endpackage

// File: rtl/tmo_evt_counter.sv
module tmo_evt_counter #(
   parameter int unsigned CNT_W = tmo_irq_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmo_i,
   input  logic             clean_i,
   input  logic [CNT_W-1:0] trig_i,
   input  logic [CNT_W-1:0] rst_i,
   output logic             set_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_width
      $error("tmo_evt_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q, run_q;
   logic [CNT_W-1:0] cnt_inc, trig_eff;
   logic [CNT_W:0]   run_inc;
   logic             run_done;

   always_comb begin
      cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
      trig_eff = (trig_i == '0) ? CNT_W'(1) : trig_i;
      run_inc  = {1'b0, run_q} + (CNT_W+1)'(1);
      run_done = (run_inc >= {1'b0, rst_i});
      set_o    = tmo_i && (cnt_inc >= trig_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= '0;
      end else if (tmo_i) begin
         cnt_q <= cnt_inc;
         run_q <= '0;
      end else if (clean_i) begin
         if (run_done) begin
            cnt_q <= '0;
            run_q <= '0;
         end else begin
            run_q <= run_inc[CNT_W-1:0];
         end
      end
   end
endmodule

// File: rtl/bo_edge_sync.sv
module bo_edge_sync #(
   parameter int unsigned          STAGES = tmo_irq_pkg::DEF_SYNC_STAGES,
   parameter tmo_irq_pkg::edge_sel_e EDGE = tmo_irq_pkg::EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic evt_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bo_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   if (EDGE == tmo_irq_pkg::EDGE_RISE) begin : g_rise
      assign evt_o = sync_q[STAGES-1] & ~prev_q;
   end else begin : g_fall
      assign evt_o = ~sync_q[STAGES-1] & prev_q;
   end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned NSRC = tmo_irq_pkg::DEF_OUTS + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic            clr_we_i,
   input  logic [NSRC-1:0] clr_data_i,
   input  logic            mask_we_i,
   input  logic [NSRC-1:0] mask_data_i,
   output logic [NSRC-1:0] status_o,
   output logic [NSRC-1:0] mask_o,
   output logic            irq_o
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("irq_status_bank: NSRC must be at least 1");
   end

   logic [NSRC-1:0] clr_vec;
   assign clr_vec = clr_we_i ? clr_data_i : '0;

   for (genvar b = 0; b < NSRC; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              status_o[b] <= 1'b0;
         else if (set_i[b])       status_o[b] <= 1'b1;
         else if (clr_vec[b])     status_o[b] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_o <= '0;
      else if (mask_we_i) mask_o <= mask_data_i;
   end

   assign irq_o = |(status_o & ~mask_o);
endmodule

// File: rtl/tmo_irq_ctrl.sv
module tmo_irq_ctrl #(
   parameter int unsigned N_OUT       = tmo_irq_pkg::DEF_OUTS,
   parameter int unsigned CNT_W       = tmo_irq_pkg::DEF_CNT_W,
   parameter int unsigned SYNC_STAGES = tmo_irq_pkg::DEF_SYNC_STAGES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_OUT-1:0] tmo_evt_i,
   input  logic [N_OUT-1:0] clean_evt_i,
   input  logic             vbat_low_i,
   input  logic [CNT_W-1:0] trig_cfg_i,
   input  logic [CNT_W-1:0] reset_cfg_i,
   input  logic             clr_we_i,
   input  logic [N_OUT:0]   clr_data_i,
   input  logic             mask_we_i,
   input  logic [N_OUT:0]   mask_data_i,
   output logic [N_OUT:0]   status_o,
   output logic [N_OUT:0]   mask_o,
   output logic             irq_o
);
   localparam int unsigned NSRC   = N_OUT + 1;
   localparam int unsigned BO_BIT = N_OUT;

   if (N_OUT < 1 || N_OUT > 16) begin : g_bad_outs
      $error("tmo_irq_ctrl: N_OUT out of range 1..16");
   end

   logic [NSRC-1:0] set_req;
   logic            bo_rise;

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      tmo_evt_counter #(.CNT_W(CNT_W)) cnt_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .tmo_i   (tmo_evt_i[o]),
         .clean_i (clean_evt_i[o]),
         .trig_i  (trig_cfg_i),
         .rst_i   (reset_cfg_i),
         .set_o   (set_req[o])
      );
   end

   bo_edge_sync #(
      .STAGES (SYNC_STAGES),
      .EDGE   (tmo_irq_pkg::EDGE_RISE)
   ) bo_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (vbat_low_i),
      .evt_o   (bo_rise)
   );

   assign set_req[BO_BIT] = bo_rise;

   irq_status_bank #(.NSRC(NSRC)) bank_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (set_req),
      .clr_we_i    (clr_we_i),
      .clr_data_i  (clr_data_i),
      .mask_we_i   (mask_we_i),
      .mask_data_i (mask_data_i),
      .status_o    (status_o),
      .mask_o      (mask_o),
      .irq_o       (irq_o)
   );
endmodule

// File: rtl/tmo_irq_ctrl_chk.sv
module tmo_irq_ctrl_chk #(
   parameter int unsigned N_OUT = tmo_irq_pkg::DEF_OUTS
) (
   input logic           clk,
   input logic           rst_n,
   input logic [N_OUT:0] set_req,
   input logic           bo_rise,
   input logic           clr_we_i,
   input logic [N_OUT:0] clr_data_i,
   input logic           mask_we_i,
   input logic [N_OUT:0] mask_data_i,
   input logic [N_OUT:0] status_o,
   input logic [N_OUT:0] mask_o,
   input logic           irq_o
);
   for (genvar b = 0; b <= N_OUT; b++) begin : g_bit
      // R2 / R9: a set request lands in status on the next edge
      p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
         set_req[b] |=> status_o[b]);
      // R6: sticky without a clear
      p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (status_o[b] && !(clr_we_i && clr_data_i[b])) |=> status_o[b]);
      // R6 / R7: a clear with no competing set empties the bit
      p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we_i && clr_data_i[b] && !set_req[b]) |=> !status_o[b]);
   end

   // R8: fully masked means no interrupt
   p_all_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_o) |-> !irq_o);
   // R8: mask write takes effect
   p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we_i |=> (mask_o == $past(mask_data_i)));
   // R9: one event per crossing
   p_bo_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bo_rise |=> !bo_rise);
endmodule

bind tmo_irq_ctrl tmo_irq_ctrl_chk #(.N_OUT(N_OUT)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .set_req     (set_req),
   .bo_rise     (bo_rise),
   .clr_we_i    (clr_we_i),
   .clr_data_i  (clr_data_i),
   .mask_we_i   (mask_we_i),
   .mask_data_i (mask_data_i),
   .status_o    (status_o),
   .mask_o      (mask_o),
   .irq_o       (irq_o)
);

// File: tb/tmo_irq_ctrl_tb.sv
`timescale 1ns/1ps
module tmo_irq_ctrl_tb_top;
   localparam int N_OUT = 4;
   localparam int CNT_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_OUT-1:0] tmo_evt = '0, clean_evt = '0;
   logic             vbat_low = 1'b0;
   logic [CNT_W-1:0] trig_cfg = '0, reset_cfg = '0;
   logic             clr_we = 1'b0, mask_we = 1'b0;
   logic [N_OUT:0]   clr_data = '0, mask_data = '0;
   logic [N_OUT:0]   status, mask;
   logic             irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   tmo_irq_ctrl #(.N_OUT(N_OUT), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .tmo_evt_i(tmo_evt), .clean_evt_i(clean_evt),
      .vbat_low_i(vbat_low), .trig_cfg_i(trig_cfg), .reset_cfg_i(reset_cfg),
      .clr_we_i(clr_we), .clr_data_i(clr_data), .mask_we_i(mask_we),
      .mask_data_i(mask_data), .status_o(status), .mask_o(mask), .irq_o(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tmo_evt = '0; clean_evt = '0; vbat_low = 1'b0;
      clr_we = 1'b0; mask_we = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // each helper drives at a falling edge and returns at the next falling edge
   task automatic tmo(input int o);
      tmo_evt[o] = 1'b1; @(negedge clk); tmo_evt[o] = 1'b0;
   endtask
   task automatic clean(input int o);
      clean_evt[o] = 1'b1; @(negedge clk); clean_evt[o] = 1'b0;
   endtask
   task automatic clr(input logic [N_OUT:0] d);
      clr_we = 1'b1; clr_data = d; @(negedge clk); clr_we = 1'b0;
   endtask
   task automatic wmask(input logic [N_OUT:0] d);
      mask_we = 1'b1; mask_data = d; @(negedge clk); mask_we = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 status", int'(status), 0);
      chk("R1 mask", int'(mask), 0);
      chk("R1 irq", int'(irq), 0);
   endtask

   task automatic t_trigger();
      do_reset(); trig_cfg = 3; reset_cfg = 15;
      tmo(1); tmo(1);
      chk("R2 below trigger", int'(status), 0);
      tmo(1);
      chk("R2 at trigger", int'(status), 'h02);
      chk("R2 irq", int'(irq), 1);
   endtask

   task automatic t_trig_zero();
      do_reset(); trig_cfg = 0; reset_cfg = 15;
      tmo(2);
      chk("R3 zero trigger", int'(status), 'h04);
   endtask

   task automatic t_clean_run();
      do_reset(); trig_cfg = 3; reset_cfg = 2;
      tmo(0); tmo(0); clean(0); clean(0); tmo(0); tmo(0);
      chk("R4 run cleared tally", int'(status), 0);
      tmo(0);
      chk("R4 count after clear", int'(status), 'h01);
      do_reset(); trig_cfg = 3; reset_cfg = 2;
      tmo(0); tmo(0); clean(0); tmo(0);
      chk("R4 short run keeps tally", int'(status), 'h01);
      do_reset(); trig_cfg = 4; reset_cfg = 2;
      tmo(3); tmo(3); clean(3); tmo(3); clean(3); tmo(3);
      chk("R4 timeout restarts run", int'(status), 'h08);
   endtask

   task automatic t_rst_zero();
      do_reset(); trig_cfg = 2; reset_cfg = 0;
      tmo(1); clean(1); tmo(1);
      chk("R5 single clean clears", int'(status), 0);
      tmo(1);
      chk("R5 count resumes", int'(status), 'h02);
   endtask

   task automatic t_w1c();
      do_reset(); trig_cfg = 1; reset_cfg = 15;
      tmo(0); tmo(3);
      clr('0);
      repeat (3) @(negedge clk);
      chk("R6 zero clear keeps", int'(status), 'h09);
      clr('h01);
      chk("R6 w1c", int'(status), 'h08);
   endtask

   task automatic t_set_wins();
      do_reset(); trig_cfg = 1; reset_cfg = 15;
      tmo(2);
      tmo_evt[2] = 1'b1; clr_we = 1'b1; clr_data = 'h04;
      @(negedge clk);
      tmo_evt[2] = 1'b0; clr_we = 1'b0;
      chk("R7 set beats clear", int'(status), 'h04);
   endtask

   task automatic t_mask();
      do_reset(); trig_cfg = 1; reset_cfg = 15;
      wmask('h1F);
      chk("R8 mask readback", int'(mask), 'h1F);
      tmo(1);
      chk("R8 masked status recorded", int'(status), 'h02);
      chk("R8 masked irq low", int'(irq), 0);
      wmask('h1D);
      chk("R8 unmasked irq high", int'(irq), 1);
   endtask

   task automatic t_brownout();
      do_reset(); trig_cfg = 15; reset_cfg = 15;
      vbat_low = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 not yet after two edges", int'(status), 0);
      @(negedge clk);
      chk("R9 set on third edge", int'(status), 'h10);
      clr('h10);
      repeat (8) @(negedge clk);
      chk("R9 held level no re-raise", int'(status), 0);
      vbat_low = 1'b0;
      repeat (4) @(negedge clk);
      vbat_low = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 new crossing", int'(status), 'h10);
   endtask

   task automatic t_saturate();
      do_reset(); trig_cfg = 15; reset_cfg = 15;
      for (int k = 0; k < 15; k++) tmo(2);
      chk("R10 reach max trigger", int'(status), 'h04);
      clr('h04);
      chk("R10 cleared", int'(status), 0);
      tmo(2);
      chk("R10 saturated re-raise", int'(status), 'h04);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_trigger();
      t_trig_zero();
      t_clean_run();
      t_rst_zero();
      t_w1c();
      t_set_wins();
      t_mask();
      t_brownout();
      t_saturate();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule